// File: doc/BRIEF.md
# 128-bit Word Pack and Interleave Permuter

This block rearranges the 32-bit words, halfwords and bytes of two 128-bit source operands into one 128-bit result. It sits next to a lane ALU behind a shared instruction decoder. Each cycle it receives an instruction word together with the two source values already read from the register file. Within the block's own opcode space it recognises a pack, three lower interleaves (byte, halfword, word), an upper word interleave and a rotate of the lower three words. The result is produced using only wiring and multiplexers. The operands are treated as words w3..w0, where w3 is the most significant.

The instruction word uses a fixed layout. The major opcode is bits [31:26] and must be 011100. The first source index (rs) is bits [25:21] and the second source index (rt) is bits [20:16]. The destination index (rd) is bits [15:11], the sub-operation is bits [10:6] and the class selector is bits [5:0]. The class selector values are 001000 for class 0, 101000 for class 1 and 001001 for class 2. A source index of 0 names the zero register, so that operand is replaced by 128 zero bits whatever value is on the data input.

All outputs are registered and appear one clock after the instruction is presented. The outputs are the result, the destination index, a write enable, and a flag that marks a valid instruction this block does not handle. The shared decoder can then route that instruction elsewhere.

Top module: `word_permuter`

## Requirements
- R1: Pack (class 0, sub-op 10011) produces, from high word to low word, {rs.w2, rs.w0, rt.w2, rt.w0}.
- R2: Byte interleave-lower (class 0, sub-op 11010) places byte i of the lower 64 bits of rt at result byte 2i and byte i of the lower 64 bits of rs at result byte 2i+1, for i = 0..7.
- R3: Halfword interleave-lower (class 0, sub-op 10110) places halfword i of the lower 64 bits of rt at result halfword 2i and the matching rs halfword at result halfword 2i+1, for i = 0..3.
- R4: Word interleave-lower (class 0, sub-op 10010) produces {rs.w1, rt.w1, rs.w0, rt.w0}.
- R5: Word interleave-upper (class 1, sub-op 10010) produces {rs.w3, rt.w3, rs.w2, rt.w2}.
- R6: Rotate-three-words (class 2, sub-op 11111, rs field 00000) produces {rt.w3, rt.w0, rt.w2, rt.w1}.
- R7: A source index of 0 reads as 128 zero bits for every operation, so a rotate with rt index 0 yields all zeros.
- R8: A handled instruction with destination index 0 produces no write. Otherwise the write enable is raised with destIdx equal to the rd field. destIdx is 0 whenever no write is made.
- R9: A valid instruction outside the handled set raises notHandled, makes no write and yields a zero result. This includes a wrong major opcode, an unknown sub-op or class, and a rotate with a non-zero rs field.
- R10: After reset all outputs are zero, and each instruction's outputs appear exactly one clock after it is presented.
- R11: A cycle with instrValid low produces neither a write nor notHandled in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rsData | input | 128 | Value of the register named by the rs field |
| rtData | input | 128 | Value of the register named by the rt field |
| resultOut | output | 128 | Permuted result |
| destIdx | output | 5 | Destination register index for the write |
| wrEn | output | 1 | Result is to be written to destIdx |
| notHandled | output | 1 | Valid instruction is not one this block executes |

## Verification
The two functions that can meet in one instruction are zero-register substitution and write suppression. The sweep provokes this by pairing source index 0 with destination index 0 on every handled operation. The result is judged against a bench model that applies the zero substitution, and the write enable and destIdx are judged separately. The sweep also visits every sub-op under every class selector, plus a wrong major opcode, so the notHandled flag is checked against the write enable in the same cycle. Rotates carrying a non-zero rs field are part of the sweep and must be rejected.

// File: rtl/permuter_pkg.sv
package permuter_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int SUB_W   = 5;
  localparam int FN_W    = 6;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_MAJOR = 6'b011100;
  localparam logic [FN_W-1:0]  FN_CLS0   = 6'b001000;
  localparam logic [FN_W-1:0]  FN_CLS1   = 6'b101000;
  localparam logic [FN_W-1:0]  FN_CLS2   = 6'b001001;

  localparam logic [SUB_W-1:0] SUB_PACK  = 5'b10011;
  localparam logic [SUB_W-1:0] SUB_ILB   = 5'b11010;
  localparam logic [SUB_W-1:0] SUB_ILH   = 5'b10110;
  localparam logic [SUB_W-1:0] SUB_WORD  = 5'b10010;
  localparam logic [SUB_W-1:0] SUB_ROT   = 5'b11111;

  localparam int SEL_PACK = 0;
  localparam int SEL_ILB  = 1;
  localparam int SEL_ILH  = 2;
  localparam int SEL_ILW  = 3;
  localparam int SEL_IUW  = 4;
  localparam int SEL_ROT  = 5;
  localparam int SEL_N    = 6;

  typedef enum logic [2:0] {
    OP_NONE, OP_PACK, OP_ILB, OP_ILH, OP_ILW, OP_IUW, OP_ROT
  } permOp_e;

  typedef struct packed {
    logic [SEL_N-1:0] laneSel;
    logic             zeroRs;
    logic             zeroRt;
    logic             doWrite;
    logic             unhandled;
    logic [IDX_W-1:0] dest;
  } permStrobes_t;
endpackage

// File: rtl/permuter_ctrl.sv
module permuter_ctrl
  import permuter_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  output permStrobes_t       strobes
);
  logic [OPC_W-1:0] opcode;
  logic [IDX_W-1:0] fieldRs;
  logic [IDX_W-1:0] fieldRt;
  logic [IDX_W-1:0] fieldRd;
  logic [SUB_W-1:0] subOp;
  logic [FN_W-1:0]  classSel;
  permOp_e          op;
  logic             known;

  assign opcode   = instr[31:26];
  assign fieldRs  = instr[25:21];
  assign fieldRt  = instr[20:16];
  assign fieldRd  = instr[15:11];
  assign subOp    = instr[10:6];
  assign classSel = instr[5:0];

  always_comb begin
    op = OP_NONE;
    if (opcode == OPC_MAJOR) begin
      unique case (classSel)
        FN_CLS0: begin
          if (subOp == SUB_PACK)      op = OP_PACK;
          else if (subOp == SUB_ILB)  op = OP_ILB;
          else if (subOp == SUB_ILH)  op = OP_ILH;
          else if (subOp == SUB_WORD) op = OP_ILW;
        end
        FN_CLS1: begin
          if (subOp == SUB_WORD) op = OP_IUW;
        end
        FN_CLS2: begin
          if (subOp == SUB_ROT && fieldRs == '0) op = OP_ROT;
        end
        default: op = OP_NONE;
      endcase
    end
  end

  assign known = (op != OP_NONE);

  always_comb begin
    strobes = '0;
    if (instrValid) begin
      case (op)
        OP_PACK: strobes.laneSel[SEL_PACK] = 1'b1;
        OP_ILB:  strobes.laneSel[SEL_ILB]  = 1'b1;
        OP_ILH:  strobes.laneSel[SEL_ILH]  = 1'b1;
        OP_ILW:  strobes.laneSel[SEL_ILW]  = 1'b1;
        OP_IUW:  strobes.laneSel[SEL_IUW]  = 1'b1;
        OP_ROT:  strobes.laneSel[SEL_ROT]  = 1'b1;
        default: strobes.laneSel = '0;
      endcase
      strobes.doWrite   = known && (fieldRd != '0);
      strobes.unhandled = !known;
      strobes.dest      = (known && fieldRd != '0) ? fieldRd : '0;
    end
    strobes.zeroRs = (fieldRs == '0);
    strobes.zeroRt = (fieldRt == '0);
  end
endmodule

// File: rtl/permuter_interleave.sv
module permuter_interleave #(
  parameter int HALF_W = 64,
  parameter int ELEM_W = 8
) (
  input  logic [HALF_W-1:0]   hiSrc,
  input  logic [HALF_W-1:0]   loSrc,
  output logic [2*HALF_W-1:0] merged
);
  localparam int PAIRS = HALF_W / ELEM_W;

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign merged[(2*i)*ELEM_W   +: ELEM_W] = loSrc[i*ELEM_W +: ELEM_W];
    assign merged[(2*i+1)*ELEM_W +: ELEM_W] = hiSrc[i*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/permuter_datapath.sv
module permuter_datapath
  import permuter_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  permStrobes_t      strobes,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [DATA_W-1:0] resultOut,
  output logic [IDX_W-1:0]  destIdx,
  output logic              wrEn,
  output logic              notHandled
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NWORDS = DATA_W / WORD_W;

  logic [DATA_W-1:0] srcA;
  logic [DATA_W-1:0] srcB;
  logic [WORD_W-1:0] wA [NWORDS];
  logic [WORD_W-1:0] wB [NWORDS];
  logic [DATA_W-1:0] cand [SEL_N];
  logic [DATA_W-1:0] nextRes;

  assign srcA = strobes.zeroRs ? '0 : rsData;
  assign srcB = strobes.zeroRt ? '0 : rtData;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign wA[w] = srcA[w*WORD_W +: WORD_W];
    assign wB[w] = srcB[w*WORD_W +: WORD_W];
  end

  assign cand[SEL_PACK] = {wA[2], wA[0], wB[2], wB[0]};
  assign cand[SEL_ROT]  = {wB[3], wB[0], wB[2], wB[1]};

  permuter_interleave #(.HALF_W(HALF_W), .ELEM_W(8)) u_ilByte (
    .hiSrc(srcA[HALF_W-1:0]), .loSrc(srcB[HALF_W-1:0]), .merged(cand[SEL_ILB]));

  permuter_interleave #(.HALF_W(HALF_W), .ELEM_W(16)) u_ilHalf (
    .hiSrc(srcA[HALF_W-1:0]), .loSrc(srcB[HALF_W-1:0]), .merged(cand[SEL_ILH]));

  permuter_interleave #(.HALF_W(HALF_W), .ELEM_W(WORD_W)) u_ilWordLo (
    .hiSrc(srcA[HALF_W-1:0]), .loSrc(srcB[HALF_W-1:0]), .merged(cand[SEL_ILW]));

  permuter_interleave #(.HALF_W(HALF_W), .ELEM_W(WORD_W)) u_ilWordHi (
    .hiSrc(srcA[DATA_W-1:HALF_W]), .loSrc(srcB[DATA_W-1:HALF_W]), .merged(cand[SEL_IUW]));

  always_comb begin
    nextRes = '0;
    for (int k = 0; k < SEL_N; k++) begin
      if (strobes.laneSel[k]) nextRes = nextRes | cand[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut  <= '0;
      destIdx    <= '0;
      wrEn       <= 1'b0;
      notHandled <= 1'b0;
    end else begin
      resultOut  <= nextRes;
      destIdx    <= strobes.dest;
      wrEn       <= strobes.doWrite;
      notHandled <= strobes.unhandled;
    end
  end
endmodule

// File: rtl/word_permuter.sv
module word_permuter
  import permuter_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int WORD_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rsData,
  input  logic [DATA_W-1:0]  rtData,
  output logic [DATA_W-1:0]  resultOut,
  output logic [IDX_W-1:0]   destIdx,
  output logic               wrEn,
  output logic               notHandled
);
  permStrobes_t strobes;

  permuter_ctrl u_ctrl (
    .instrValid(instrValid),
    .instr     (instr),
    .strobes   (strobes)
  );

  permuter_datapath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rsData    (rsData),
    .rtData    (rtData),
    .resultOut (resultOut),
    .destIdx   (destIdx),
    .wrEn      (wrEn),
    .notHandled(notHandled)
  );
endmodule

// File: rtl/word_permuter_chk.sv
module word_permuter_chk (
  input logic         clk,
  input logic         rstN,
  input logic         instrValid,
  input logic [31:0]  instr,
  input logic [127:0] rsData,
  input logic [127:0] rtData,
  input logic [127:0] resultOut,
  input logic [4:0]   destIdx,
  input logic         wrEn,
  input logic         notHandled
);
  logic isPack;
  logic isRot;

  assign isPack = instr[31:26] == 6'b011100 && instr[5:0] == 6'b001000 &&
                  instr[10:6] == 5'b10011;
  assign isRot  = instr[31:26] == 6'b011100 && instr[5:0] == 6'b001001 &&
                  instr[10:6] == 5'b11111 && instr[25:21] == 5'd0;

  // R1: pack word order, both sources non-zero registers
  assert_pack_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isPack && instr[25:21] != 5'd0 && instr[20:16] != 5'd0) |=>
      resultOut == {$past(rsData[95:64]), $past(rsData[31:0]),
                    $past(rtData[95:64]), $past(rtData[31:0])});

  // R6: rotate keeps top word, rotates the lower three
  assert_rotate_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isRot && instr[20:16] != 5'd0) |=>
      resultOut == {$past(rtData[127:96]), $past(rtData[31:0]),
                    $past(rtData[95:64]), $past(rtData[63:32])});

  // R7: rotate of the zero register gives zero
  assert_rotate_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isRot && instr[20:16] == 5'd0) |=> resultOut == '0);

  // R8: a write never targets index 0
  assert_no_write_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> destIdx != 5'd0);

  // R9: rejection and write are exclusive, rejected result is zero
  assert_reject_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    notHandled |-> (!wrEn && resultOut == '0));

  // R11: idle input gives idle output
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> (!wrEn && !notHandled));
endmodule

bind word_permuter word_permuter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrValid(instrValid),
  .instr     (instr),
  .rsData    (rsData),
  .rtData    (rtData),
  .resultOut (resultOut),
  .destIdx   (destIdx),
  .wrEn      (wrEn),
  .notHandled(notHandled)
);

// File: tb/word_permuter_bench.sv
`timescale 1ns/1ps
module word_permuter_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instrValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] rsData = '0;
  logic [127:0] rtData = '0;
  logic [127:0] resultOut;
  logic [4:0]   destIdx;
  logic         wrEn;
  logic         notHandled;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  word_permuter u_word_permuter (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .rsData(rsData), .rtData(rtData), .resultOut(resultOut),
    .destIdx(destIdx), .wrEn(wrEn), .notHandled(notHandled)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h instr=%h", tag, act, exp, instr);
    end
  endtask

  function automatic logic [127:0] mkOperand(input int seed);
    logic [127:0] v;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] x;
      x = seed * 32'h9E3779B9 + w * 32'h7F4A7C15 + 32'h1234567;
      x = x ^ (x >> 13);
      x = x * 32'h85EBCA6B;
      x = x ^ (x >> 16);
      v[w*32 +: 32] = x;
    end
    return v;
  endfunction

  // interleave model: element width e, source base bit 0 or 64
  function automatic logic [127:0] model_il(input logic [127:0] a, input logic [127:0] b,
                                            input int e, input int base);
    logic [127:0] r;
    for (int bit_i = 0; bit_i < 128; bit_i++) begin
      int idx;
      int pos;
      idx = bit_i / e;
      pos = bit_i % e;
      if (idx % 2 == 1) r[bit_i] = a[base + (idx / 2) * e + pos];
      else              r[bit_i] = b[base + (idx / 2) * e + pos];
    end
    return r;
  endfunction

  task automatic runOne(input logic [5:0] opc, input logic [4:0] fRs, input logic [4:0] fRt,
                        input logic [4:0] fRd, input logic [4:0] sub, input logic [5:0] fn,
                        input int seed);
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] expRes;
    string opTag;
    bit known;
    a = mkOperand(seed);
    b = mkOperand(seed + 7777);
    instr = {opc, fRs, fRt, fRd, sub, fn};
    rsData = a;
    rtData = b;
    instrValid = 1'b1;
    if (fRs == 0) a = '0;
    if (fRt == 0) b = '0;
    known = 1'b0;
    expRes = '0;
    opTag = "R9";
    if (opc == 6'b011100) begin
      if (fn == 6'b001000 && sub == 5'b10011) begin
        known = 1; opTag = "R1";
        expRes = {a[95:64], a[31:0], b[95:64], b[31:0]};
      end else if (fn == 6'b001000 && sub == 5'b11010) begin
        known = 1; opTag = "R2"; expRes = model_il(a, b, 8, 0);
      end else if (fn == 6'b001000 && sub == 5'b10110) begin
        known = 1; opTag = "R3"; expRes = model_il(a, b, 16, 0);
      end else if (fn == 6'b001000 && sub == 5'b10010) begin
        known = 1; opTag = "R4"; expRes = model_il(a, b, 32, 0);
      end else if (fn == 6'b101000 && sub == 5'b10010) begin
        known = 1; opTag = "R5"; expRes = model_il(a, b, 32, 64);
      end else if (fn == 6'b001001 && sub == 5'b11111 && fRs == 0) begin
        known = 1; opTag = "R6";
        expRes = {b[127:96], b[31:0], b[95:64], b[63:32]};
      end
    end
    @(negedge clk);
    if (known) begin
      if (fRs == 0 || fRt == 0) check("R7", resultOut, expRes);
      else                      check(opTag, resultOut, expRes);
      check("R8 wrEn", {127'd0, wrEn}, {127'd0, fRd != 0});
      check("R8 destIdx", {123'd0, destIdx}, {123'd0, (fRd != 0) ? fRd : 5'd0});
      check("R9 flag", {127'd0, notHandled}, 128'd0);
    end else begin
      check("R9 flag", {127'd0, notHandled}, 128'd1);
      check("R9 wrEn", {127'd0, wrEn}, 128'd0);
      check("R9 result", resultOut, 128'd0);
    end
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] fns [4];
    logic [4:0] rsSet [3];
    logic [4:0] rtSet [2];
    logic [4:0] rdSet [2];
    int seed;
    fns[0] = 6'b001000; fns[1] = 6'b101000; fns[2] = 6'b001001; fns[3] = 6'b000000;
    rsSet[0] = 5'd0; rsSet[1] = 5'd1; rsSet[2] = 5'd7;
    rtSet[0] = 5'd0; rtSet[1] = 5'd3;
    rdSet[0] = 5'd0; rdSet[1] = 5'd21;
    seed = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result", resultOut, 128'd0);
    check("R10 wrEn/flag/dest", {121'd0, destIdx, wrEn, notHandled}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    check("R11", {126'd0, wrEn, notHandled}, 128'd0);
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 32; s++)
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 2; j++)
            for (int k = 0; k < 2; k++) begin
              runOne(6'b011100, rsSet[i], rtSet[j], rdSet[k], 5'(s), fns[f], seed);
              seed++;
            end
    // R9: wrong major opcode carrying otherwise valid fields
    for (int s = 0; s < 8; s++) begin
      runOne(6'b011110, 5'd2, 5'd4, 5'd9, 5'b10011, 6'b001000, seed + s);
    end
    // R11: valid drops after a writing instruction
    runOne(6'b011100, 5'd5, 5'd6, 5'd8, 5'b10011, 6'b001000, 99);
    instrValid = 1'b0;
    @(negedge clk);
    check("R11 idle", {126'd0, wrEn, notHandled}, 128'd0);
    // R10: back-to-back results with one cycle latency
    runOne(6'b011100, 5'd5, 5'd6, 5'd8, 5'b11010, 6'b001000, 500);
    runOne(6'b011100, 5'd5, 5'd6, 5'd8, 5'b10010, 6'b101000, 501);
    runOne(6'b011100, 5'd0, 5'd6, 5'd8, 5'b11111, 6'b001001, 502);
    instrValid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule